// File: doc/BRIEF.md
# Octal DAC Register Control Core

This block is the digital register core of an eight-channel, 16-bit voltage-output converter. A host writes to it over a three-wire, write-only serial port made of a serial clock, an active-low frame select and a data line. Every complete frame carries a command, a channel address and a 16-bit data word. The core keeps two registers per channel. The input register receives new codes. The DAC register holds the code the analog stage actually converts. Because of this double buffering, all channels can be loaded first and then switched together.

Two pins bypass the serial port. An active-low load pin copies the input register into the DAC register on every channel whose mask bit is clear. A falling edge on the active-low clear pin forces a selectable clear code into every DAC register. The core also holds a 2-bit power mode for each channel and an enable flag for the internal reference. All pins are sampled in the core's own clock domain through two-stage synchronisers, so the core clock must run at several times the serial clock rate.

Top module: `octalDacCore`

## Requirements
- R1: After reset, all DAC registers read 0x0000, all power modes read 0, the reference flag is 0, the clear code selects zero scale and every mask bit is 0.
- R2: A frame is 32 bits, shifted MSB first and sampled on falling serial-clock edges while the frame select is low. Bits 27:24 hold the command, bits 23:20 the address and bits 19:4 the data. Bits 31:28 and 3:0 are ignored. The frame executes on the 32nd falling edge.
- R3: Command 0 writes the data to the input register of the addressed channel and leaves its DAC register unchanged.
- R4: Command 1 copies the input register of the addressed channel into its DAC register.
- R5: Command 3 writes the data to both the input register and the DAC register of the addressed channel.
- R6: Command 2 writes the data to the input register of the addressed channel, then copies every channel's input register into its DAC register.
- R7: Address 15 selects all eight channels. Addresses 8 to 14 select no channel.
- R8: Command 4 sets the power mode to data bits 9:8 on each channel whose bit is set in data bits 7:0 (bit i is channel i). The modes are 0 normal, 1 one-kilohm pull-down, 2 hundred-kilohm pull-down and 3 high impedance.
- R9: Command 6 loads the mask from data bits 7:0. While the load pin is low, each channel with mask bit 0 copies its input register into its DAC register. A channel with mask bit 1 ignores the pin.
- R10: Command 5 selects the clear code from data bits 1:0: 0 gives 0x0000, 1 gives 0x8000, 2 gives 0xFFFF and 3 does nothing. A falling edge on the clear pin loads that code into all DAC registers. Input-register writes made while the pin is still low are kept, and the DAC registers hold the clear code until the next update.
- R11: Command 8 sets the reference flag to data bit 0.
- R12: Command 7 returns every register to its R1 state.
- R13: A frame cut short by the frame select going high before 32 falling edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on falling edges |
| syncN | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| ldacN | input | 1 | Active-low load pin (level sensitive) |
| clrN | input | 1 | Active-low clear pin (falling-edge sensitive) |
| dacVal | output | 128 | DAC register codes, channel i in bits 16i+15:16i |
| pwrMode | output | 16 | Power modes, channel i in bits 2i+1:2i |
| refOn | output | 1 | Internal reference enable |

## Verification
After the 32nd falling serial edge, a frame's result reaches the outputs four core cycles later: two synchroniser stages, the shift-and-execute register, and the register bank. The clear and load pins pass through two synchronisers and then the bank, so they take three cycles. The bench holds the frame select low for two extra cycles after the last bit. It then waits eight more cycles before comparing every output with its model, and it waits six cycles after changing a pin. Every sample is therefore taken after the slowest path has settled and before the next stimulus starts.

// File: rtl/dacCorePkg.sv
package dacCorePkg;
  parameter int NCH        = 8;
  parameter int DW         = 16;
  parameter int CMD_W      = 4;
  parameter int ADDR_W     = 4;
  parameter int DC_BITS    = 4;
  parameter int FEAT_BITS  = 4;
  localparam int PAYLOAD_W  = CMD_W + ADDR_W + DW;
  localparam int FRAME_BITS = DC_BITS + PAYLOAD_W + FEAT_BITS;
  localparam int PWR_LSB    = NCH;
  localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD         = 4'd0,
    CMD_UPDATE       = 4'd1,
    CMD_LOAD_UPD_ALL = 4'd2,
    CMD_LOAD_UPD     = 4'd3,
    CMD_POWER        = 4'd4,
    CMD_CLRCODE      = 4'd5,
    CMD_MASK         = 4'd6,
    CMD_RESET        = 4'd7,
    CMD_REF          = 4'd8
  } cmd_e;

  typedef struct packed {
    logic [NCH-1:0] chSel;
    logic [DW-1:0]  data;
    logic           load;
    logic           update;
    logic           updateAll;
    logic           setPwr;
    logic           setClr;
    logic           setMask;
    logic           softReset;
    logic           setRef;
  } ctrlStrobe_t;
endpackage

// File: rtl/dacSerialCtrl.sv
module dacSerialCtrl
  import dacCorePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        syncN,
  input  logic        sdin,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] KEEP_LO   = CNT_W'(DC_BITS);
  localparam logic [CNT_W-1:0] KEEP_HI   = CNT_W'(DC_BITS + PAYLOAD_W);

  logic [2:0] sclkS;
  logic [1:0] syncS, dinS;
  logic [CNT_W-1:0] bitCnt;
  logic [PAYLOAD_W-1:0] payload;
  logic exec;
  logic sclkFall, frameOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS <= 3'b000;
      syncS <= 2'b11;
      dinS  <= 2'b00;
    end else begin
      sclkS <= {sclkS[1:0], sclk};
      syncS <= {syncS[0], syncN};
      dinS  <= {dinS[0], sdin};
    end
  end

  assign sclkFall  = sclkS[2] & ~sclkS[1];
  assign frameOpen = ~syncS[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      payload <= '0;
      exec    <= 1'b0;
    end else begin
      exec <= 1'b0;
      if (!frameOpen) begin
        bitCnt <= '0;
      end else if (sclkFall && bitCnt <= LAST_BIT) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt >= KEEP_LO && bitCnt < KEEP_HI)
          payload <= {payload[PAYLOAD_W-2:0], dinS[1]};
        if (bitCnt == LAST_BIT) exec <= 1'b1;
      end
    end
  end

  logic [CMD_W-1:0]  cmdField;
  logic [ADDR_W-1:0] addrField;
  assign cmdField  = payload[PAYLOAD_W-1 -: CMD_W];
  assign addrField = payload[DW +: ADDR_W];

  always_comb begin
    strobe      = '0;
    strobe.data = payload[DW-1:0];
    for (int i = 0; i < NCH; i++)
      strobe.chSel[i] = (addrField == ADDR_W'(i)) || (addrField == ADDR_ALL);
    if (exec) begin
      case (cmd_e'(cmdField))
        CMD_LOAD:         strobe.load = 1'b1;
        CMD_UPDATE:       strobe.update = 1'b1;
        CMD_LOAD_UPD_ALL: begin strobe.load = 1'b1; strobe.updateAll = 1'b1; end
        CMD_LOAD_UPD:     begin strobe.load = 1'b1; strobe.update = 1'b1; end
        CMD_POWER:        strobe.setPwr = 1'b1;
        CMD_CLRCODE:      strobe.setClr = 1'b1;
        CMD_MASK:         strobe.setMask = 1'b1;
        CMD_RESET:        strobe.softReset = 1'b1;
        CMD_REF:          strobe.setRef = 1'b1;
        default:          strobe.load = 1'b0;
      endcase
    end
  end

  // R2: execution only after the last bit of a full frame
  a_r2_exec_on_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    exec |-> $past(bitCnt) == LAST_BIT);
  // R13: a deasserted frame select clears the bit count
  a_r13_abort_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    !frameOpen |=> bitCnt == '0);
  // R7: channel select is one channel, no channel or all channels
  a_r7_select_shape: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(strobe.chSel) <= 1) || (&strobe.chSel));
endmodule

// File: rtl/dacRegBank.sv
module dacRegBank
  import dacCorePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ldacN,
  input  logic                clrN,
  input  ctrlStrobe_t         st,
  output logic [NCH*DW-1:0]   dacFlat,
  output logic [NCH*2-1:0]    pwrFlat,
  output logic                refOn
);
  localparam logic [DW-1:0] MID_CODE  = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] FULL_CODE = '1;

  logic [1:0] ldacS;
  logic [2:0] clrS;
  logic [DW-1:0] inReg  [NCH];
  logic [DW-1:0] dacReg [NCH];
  logic [DW-1:0] inNext [NCH];
  logic [1:0]    pwr    [NCH];
  logic [NCH-1:0] mask;
  logic [1:0] clrCode;
  logic [DW-1:0] clearVal;
  logic clrFall, clrActive, ldacLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldacS <= 2'b11;
      clrS  <= 3'b111;
    end else begin
      ldacS <= {ldacS[0], ldacN};
      clrS  <= {clrS[1:0], clrN};
    end
  end

  assign ldacLow   = ~ldacS[1];
  assign clrFall   = clrS[2] & ~clrS[1];
  assign clrActive = clrFall && (clrCode != 2'd3);

  always_comb begin
    case (clrCode)
      2'd1:    clearVal = MID_CODE;
      2'd2:    clearVal = FULL_CODE;
      default: clearVal = '0;
    endcase
    for (int i = 0; i < NCH; i++)
      inNext[i] = (st.load && st.chSel[i]) ? st.data : inReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        inReg[i] <= '0; dacReg[i] <= '0; pwr[i] <= '0;
      end
      mask <= '0; clrCode <= '0; refOn <= 1'b0;
    end else if (st.softReset) begin
      for (int i = 0; i < NCH; i++) begin
        inReg[i] <= '0; dacReg[i] <= '0; pwr[i] <= '0;
      end
      mask <= '0; clrCode <= '0; refOn <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        inReg[i] <= inNext[i];
        if (clrActive)
          dacReg[i] <= clearVal;
        else if ((st.update && st.chSel[i]) || st.updateAll || (ldacLow && !mask[i]))
          dacReg[i] <= inNext[i];
        if (st.setPwr && st.data[i])
          pwr[i] <= st.data[PWR_LSB +: 2];
      end
      if (st.setMask) mask    <= st.data[NCH-1:0];
      if (st.setClr)  clrCode <= st.data[1:0];
      if (st.setRef)  refOn   <= st.data[0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gOut
    assign dacFlat[g*DW +: DW] = dacReg[g];
    assign pwrFlat[g*2 +: 2]   = pwr[g];
  end

  // R10: midscale clear code reaches the DAC registers after a clear edge
  a_r10_midscale_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(clrFall && clrCode == 2'd1 && !st.softReset) |-> dacReg[0] == MID_CODE);
  // R9: a masked channel holds unless a serial update, clear or reset occurs
  a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(mask[0] && !clrActive && !st.update && !st.updateAll && !st.softReset)
      |-> $stable(dacReg[0]));
  // R11: the reference flag moves only on its command or a soft reset
  a_r11_ref_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refOn) |-> $past(st.setRef || st.softReset));
  // R8: a power mode moves only on its command or a soft reset
  a_r8_pwr_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pwr[0]) |-> $past(st.setPwr || st.softReset));
endmodule

// File: rtl/octalDacCore.sv
module octalDacCore
  import dacCorePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              syncN,
  input  logic              sdin,
  input  logic              ldacN,
  input  logic              clrN,
  output logic [NCH*DW-1:0] dacVal,
  output logic [NCH*2-1:0]  pwrMode,
  output logic              refOn
);
  ctrlStrobe_t strobe;

  dacSerialCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .sdin(sdin),
    .strobe(strobe)
  );

  dacRegBank u_bank (
    .clk(clk), .rstN(rstN), .ldacN(ldacN), .clrN(clrN), .st(strobe),
    .dacFlat(dacVal), .pwrFlat(pwrMode), .refOn(refOn)
  );
endmodule

// File: tb/octalDacCore_tb.sv
`timescale 1ns/1ps
module octalDacCore_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, syncN = 1'b1, sdin = 1'b0, ldacN = 1'b1, clrN = 1'b1;
  logic [127:0] dacVal;
  logic [15:0]  pwrMode;
  logic         refOn;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  logic [15:0] expIn [8];
  logic [15:0] expDac [8];
  logic [1:0]  expPwr [8];
  logic [7:0]  expMask;
  logic [1:0]  expClr;
  logic        expRef;

  always #2.5 clk = ~clk;

  octalDacCore u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .sdin(sdin),
    .ldacN(ldacN), .clrN(clrN), .dacVal(dacVal), .pwrMode(pwrMode), .refOn(refOn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 8; i++) begin
      chk(req, $sformatf("dac%0d", i), {16'h0, dacVal[i*16 +: 16]}, {16'h0, expDac[i]});
      chk(req, $sformatf("pwr%0d", i), {30'h0, pwrMode[i*2 +: 2]}, {30'h0, expPwr[i]});
    end
    chk(req, "ref", {31'h0, refOn}, {31'h0, expRef});
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      expIn[i] = '0; expDac[i] = '0; expPwr[i] = '0;
    end
    expMask = '0; expClr = '0; expRef = 1'b0;
  endtask

  function automatic logic [7:0] selOf(input logic [3:0] addr);
    if (addr == 4'hF) return 8'hFF;
    if (addr < 4'd8)  return 8'h01 << addr;
    return 8'h00;
  endfunction

  function automatic logic [15:0] clearCode(input logic [1:0] c);
    case (c)
      2'd1:    return 16'h8000;
      2'd2:    return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelCmd(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
    logic [7:0] sel = selOf(addr);
    case (cmd)
      4'd0: for (int i = 0; i < 8; i++) if (sel[i]) expIn[i] = data;
      4'd1: for (int i = 0; i < 8; i++) if (sel[i]) expDac[i] = expIn[i];
      4'd2: begin
        for (int i = 0; i < 8; i++) if (sel[i]) expIn[i] = data;
        for (int i = 0; i < 8; i++) expDac[i] = expIn[i];
      end
      4'd3: for (int i = 0; i < 8; i++) if (sel[i]) begin expIn[i] = data; expDac[i] = data; end
      4'd4: for (int i = 0; i < 8; i++) if (data[i]) expPwr[i] = data[9:8];
      4'd5: expClr = data[1:0];
      4'd6: expMask = data[7:0];
      4'd7: modelReset();
      4'd8: expRef = data[0];
      default: ;
    endcase
  endtask

  task automatic sendFrame(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data, input int nBits);
    logic [31:0] frame = {4'hA, cmd, addr, data, 4'h5};
    @(negedge clk) syncN = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nBits; b++) begin
      sdin = frame[31-b]; sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    syncN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic doCmd(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
    sendFrame(cmd, addr, data, 32);
    modelCmd(cmd, addr, data);
  endtask

  task automatic pulseLdac();
    @(negedge clk) ldacN = 1'b0;
    repeat (6) @(negedge clk);
    ldacN = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) if (!expMask[i]) expDac[i] = expIn[i];
  endtask

  task automatic fallClr();
    @(negedge clk) clrN = 1'b0;
    repeat (6) @(negedge clk);
    if (expClr != 2'd3) for (int i = 0; i < 8; i++) expDac[i] = clearCode(expClr);
  endtask

  task automatic riseClr();
    @(negedge clk) clrN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0] rc, ra;
    logic [15:0] rd;
    void'($urandom(32'h5EED_0C7A));
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R1");

    doCmd(4'd0, 4'd2, 16'h1234);           checkAll("R2 R3");
    doCmd(4'd1, 4'd2, 16'h0000);           checkAll("R4");
    doCmd(4'd3, 4'd5, 16'hBEEF);           checkAll("R5");
    doCmd(4'd0, 4'd0, 16'h1111);
    doCmd(4'd2, 4'd1, 16'h2222);           checkAll("R6");
    doCmd(4'd0, 4'hF, 16'h4444);           checkAll("R7");
    doCmd(4'd1, 4'hF, 16'h0000);           checkAll("R7");
    doCmd(4'd3, 4'd9, 16'h9999);           checkAll("R7");
    doCmd(4'd4, 4'd0, 16'h0281);           checkAll("R8");
    doCmd(4'd4, 4'd0, 16'h0302);           checkAll("R8");
    doCmd(4'd6, 4'd0, 16'h000F);
    doCmd(4'd0, 4'hF, 16'h7777);           checkAll("R9");
    pulseLdac();                           checkAll("R9");

    doCmd(4'd5, 4'd0, 16'h0001);
    fallClr();                             checkAll("R10");
    doCmd(4'd0, 4'd3, 16'hAAAA);           checkAll("R10");
    riseClr();                             checkAll("R10");
    doCmd(4'd1, 4'd3, 16'h0000);           checkAll("R10");
    doCmd(4'd5, 4'd0, 16'h0002);
    fallClr(); riseClr();                  checkAll("R10");
    doCmd(4'd5, 4'd0, 16'h0003);
    doCmd(4'd3, 4'd6, 16'h0606);
    fallClr(); riseClr();                  checkAll("R10");

    doCmd(4'd8, 4'd0, 16'h0001);           checkAll("R11");
    doCmd(4'd8, 4'd0, 16'h0000);           checkAll("R11");
    doCmd(4'd8, 4'd0, 16'h0001);

    sendFrame(4'd3, 4'd0, 16'h5555, 20);   checkAll("R13");
    sendFrame(4'd3, 4'hF, 16'h5555, 31);   checkAll("R13");
    doCmd(4'd3, 4'd0, 16'h5A5A);           checkAll("R13");

    doCmd(4'd7, 4'd0, 16'h0000);           checkAll("R12");

    for (int n = 0; n < 60; n++) begin
      case ($urandom % 7)
        0: rc = 4'd0; 1: rc = 4'd1; 2: rc = 4'd2; 3: rc = 4'd3;
        4: rc = 4'd4; 5: rc = 4'd6; default: rc = 4'd8;
      endcase
      case ($urandom % 5)
        0:       ra = 4'hF;
        1:       ra = 4'd8 + 4'($urandom % 7);
        default: ra = 4'($urandom % 8);
      endcase
      rd = 16'($urandom);
      doCmd(rc, ra, rd);
      case (rc)
        4'd0: checkAll("R3");  4'd1: checkAll("R4");  4'd2: checkAll("R6");
        4'd3: checkAll("R5");  4'd4: checkAll("R8");  4'd6: checkAll("R9");
        default: checkAll("R11");
      endcase
      if ($urandom % 4 == 0) begin
        pulseLdac(); checkAll("R9");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule